// File: doc/BRIEF.md
# Oversampled SPI Byte Slave

This block is the serial end of a one-byte SPI exchange. The serial clock, the active-low select and the master's data line are treated as ordinary asynchronous inputs. They are brought into the fast system clock domain through flop chains. Serial clock edges are then found by comparing the synchronized clock with its value one system cycle earlier. No logic is clocked by the serial clock itself.

During one transaction the block shifts in eight bits from the master and, in the same transaction, shifts out a byte that local logic presents in parallel. Incoming data is sampled on rising serial clock edges. Outgoing data changes on falling edges. Both directions send the most significant bit first. After the eighth falling edge the received byte appears on a parallel output, where it stays until the next complete byte arrives. A one-cycle strobe marks that moment. A busy flag covers the span from the first rising edge to the last falling edge.

While select is high the block is idle and its bit position is cleared. It also keeps the next transmit byte loaded, so bit 7 is on the output line as soon as select falls. If select stays low after a byte completes, a further byte can follow at once.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, busy is 0, done is 0 and rxByte is 0.
- R2: The value on mosiIn is sampled at each rising edge of sclkIn while selN is low. The first sampled bit becomes rxByte bit 7 and the eighth becomes bit 0.
- R3: While selN is low and before the first rising edge, misoOut equals bit 7 of txByte. After each falling edge the next lower bit is driven, so the master sees txByte MSB first.
- R4: rxByte changes only when a byte completes. A transfer that is cut short leaves rxByte unchanged.
- R5: busy is 0 before the first rising edge of a byte. It is 1 from that edge until the eighth falling edge, and 0 whenever selN is high.
- R6: Each completed 8-bit transfer gives exactly one done pulse, one system cycle wide. In that cycle rxByte already holds the new byte, and busy is 0.
- R7: Raising selN mid-byte clears the bit position. It gives no done pulse, and the next transfer is received and sent correctly.
- R8: Toggling sclkIn while selN is high produces no done pulse, no busy and no change of rxByte.
- R9: If selN stays low after a byte completes, txByte is reloaded at that moment, and a second byte is exchanged in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than sclkIn |
| rst | input | 1 | Synchronous reset, active high |
| sclkIn | input | 1 | Serial clock from master, idles low |
| selN | input | 1 | Select from master, active low |
| mosiIn | input | 1 | Serial data from master |
| misoOut | output | 1 | Serial data to master |
| txByte | input | DATA_W | Byte to send on the next transfer |
| rxByte | output | DATA_W | Byte received in the last completed transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its defaults: an 8-bit byte and two synchronizer stages. The serial clock half-period is six system cycles, which exercises the synchronizer latency in full. With these values, every one of the 256 receive patterns can be swept. Each is paired with an arithmetically derived transmit byte, so every bit position in both directions is covered. Aborted bytes, serial clock activity while idle and two back-to-back bytes under one select are also within reach of this small configuration.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  // Strobes from control to datapath, valid for one system cycle.
  typedef struct packed {
    logic idle;      // select inactive: hold transmit byte, clear state
    logic sample;    // rising serial edge: shift receive bit in
    logic shiftOut;  // falling serial edge inside a byte: next transmit bit
    logic complete;  // falling serial edge after last bit: byte done
  } ctlStrobes_t;

endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int LINES = 3,
  parameter int STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] syncOut
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_slave_ctrl.sv
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclkS,
  input  logic        selS,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic             sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             gotLast;
  logic             riseEdge;
  logic             fallEdge;

  assign riseEdge = sclkS & ~sclkPrev & ~selS;
  assign fallEdge = ~sclkS & sclkPrev & ~selS;

  always_comb begin
    ctl.idle     = selS;
    ctl.sample   = riseEdge;
    ctl.shiftOut = fallEdge & ~gotLast;
    ctl.complete = fallEdge & gotLast;
  end

  always_ff @(posedge clk) begin
    if (rst) sclkPrev <= 1'b0;
    else     sclkPrev <= sclkS;
  end

  always_ff @(posedge clk) begin
    if (rst || selS) begin
      bitCnt  <= '0;
      gotLast <= 1'b0;
    end else if (riseEdge) begin
      gotLast <= (bitCnt == LAST_BIT);
      bitCnt  <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end else if (ctl.complete) begin
      gotLast <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || selS) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= ctl.complete;
      if (ctl.complete)  busy <= 1'b0;
      else if (riseEdge) busy <= 1'b1;
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r5_idle_not_busy: assert property (@(posedge clk) disable iff (rst)
    selS |=> !busy);
  a_r7_count_cleared: assert property (@(posedge clk) disable iff (rst)
    selS |=> (bitCnt == '0 && !gotLast));

endmodule

// File: rtl/spi_slave_dpath.sv
module spi_slave_dpath
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] rxByte,
  output logic              misoOut
);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (rst)                         txShift <= '0;
    else if (ctl.idle || ctl.complete) txShift <= txByte;
    else if (ctl.shiftOut)           txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)             rxShift <= '0;
    else if (ctl.sample) rxShift <= {rxShift[DATA_W-2:0], mosiS};
  end

  always_ff @(posedge clk) begin
    if (rst)               rxByte <= '0;
    else if (ctl.complete) rxByte <= rxShift;
  end

  assign misoOut = txShift[DATA_W-1];

  a_r4_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.complete |=> $stable(rxByte));
  a_r3_miso_steady: assert property (@(posedge clk) disable iff (rst)
    (!ctl.idle && !ctl.shiftOut && !ctl.complete) |=> $stable(misoOut));

endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclkIn,
  input  logic              selN,
  input  logic              mosiIn,
  output logic              misoOut,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] rxByte,
  output logic              busy,
  output logic              done
);

  localparam int LINES = 3;
  localparam logic [LINES-1:0] SYNC_RST = 3'b010;  // select resets inactive

  logic [LINES-1:0] syncVec;
  ctlStrobes_t      ctl;

  spi_slave_sync #(
    .LINES  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .rawIn  ({mosiIn, selN, sclkIn}),
    .syncOut(syncVec)
  );

  spi_slave_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .sclkS(syncVec[0]),
    .selS (syncVec[1]),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  spi_slave_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .mosiS  (syncVec[2]),
    .txByte (txByte),
    .rxByte (rxByte),
    .misoOut(misoOut)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && rxByte == '0));

endmodule

// File: tb/spi_byte_slave_tb.sv
module spi_byte_slave_tb;

  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclkIn = 1'b0;
  logic       selN = 1'b1;
  logic       mosiIn = 1'b0;
  logic       misoOut;
  logic [7:0] txByte = 8'h00;
  logic [7:0] rxByte;
  logic       busy;
  logic       done;

  int checks = 0;
  int failures = 0;
  int doneCnt = 0;
  int widePulses = 0;
  logic prevDone = 1'b0;
  logic [7:0] lastDoneRx = 8'h00;
  logic busyAtDone = 1'b0;

  always #2 clk = ~clk;

  spi_byte_slave u_dut (
    .clk(clk), .rst(rst), .sclkIn(sclkIn), .selN(selN), .mosiIn(mosiIn),
    .misoOut(misoOut), .txByte(txByte), .rxByte(rxByte), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (done) begin
        doneCnt <= doneCnt + 1;
        lastDoneRx <= rxByte;
        busyAtDone <= busy;
      end
      if (done && prevDone) widePulses <= widePulses + 1;
      prevDone <= done;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Master clocks nBits bits; returns what it saw on miso.
  task automatic shiftBits(input logic [7:0] mo, input int nBits, output logic [7:0] got);
    got = 8'h00;
    for (int b = 0; b < nBits; b++) begin
      mosiIn = mo[7-b];
      waitClk(H);
      got[7-b] = misoOut;
      if (b == 0) chk(busy == 1'b0, "R5 busy before first rise", busy, 0);
      sclkIn = 1'b1;
      waitClk(H);
      if (b == 0) chk(busy == 1'b1, "R5 busy after first rise", busy, 1);
      sclkIn = 1'b0;
    end
  endtask

  task automatic checkByteEnd(input logic [7:0] mo, input logic [7:0] tx,
                              input logic [7:0] got, input int d0);
    waitClk(H);
    chk(rxByte == mo, "R2 received byte", rxByte, mo);
    chk(got == tx, "R3 transmitted byte", got, tx);
    chk(doneCnt == d0 + 1, "R6 one done pulse", doneCnt - d0, 1);
    chk(lastDoneRx == mo, "R6 rxByte valid with done", lastDoneRx, mo);
    chk(busyAtDone == 1'b0, "R6 busy low with done", busyAtDone, 0);
    chk(busy == 1'b0, "R5 busy after last fall", busy, 0);
  endtask

  task automatic fullXfer(input logic [7:0] mo, input logic [7:0] tx);
    logic [7:0] got;
    int d0;
    txByte = tx;
    waitClk(2);
    selN = 1'b0;
    waitClk(H);
    d0 = doneCnt;
    shiftBits(mo, 8, got);
    checkByteEnd(mo, tx, got, d0);
    selN = 1'b1;
    waitClk(4);
  endtask

  initial begin
    logic [7:0] got;
    logic [7:0] keepRx;
    int d0;
    waitClk(4);
    rst = 1'b0;
    waitClk(2);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(rxByte == 8'h00, "R1 rxByte reset", rxByte, 0);

    // Exhaustive receive sweep with arithmetically derived transmit bytes.
    for (int i = 0; i < 256; i++) fullXfer(8'(i), 8'((i * 7 + 13) & 255));

    // R7 / R4: abort after four bits.
    keepRx = rxByte;
    d0 = doneCnt;
    txByte = 8'h96;
    waitClk(2);
    selN = 1'b0;
    waitClk(H);
    shiftBits(8'hA5, 4, got);
    selN = 1'b1;
    waitClk(H);
    chk(rxByte == keepRx, "R4 rxByte kept on abort", rxByte, keepRx);
    chk(doneCnt == d0, "R7 no done on abort", doneCnt - d0, 0);
    chk(busy == 1'b0, "R5 busy low after abort", busy, 0);
    fullXfer(8'h3C, 8'hC3);  // R7 next transfer clean

    // R8: serial clock activity while deselected.
    keepRx = rxByte;
    d0 = doneCnt;
    for (int k = 0; k < 10; k++) begin
      mosiIn = k[0];
      sclkIn = 1'b1;
      waitClk(H);
      chk(busy == 1'b0, "R8 busy stays low", busy, 0);
      sclkIn = 1'b0;
      waitClk(H);
    end
    chk(doneCnt == d0, "R8 no done while idle", doneCnt - d0, 0);
    chk(rxByte == keepRx, "R8 rxByte unchanged", rxByte, keepRx);
    fullXfer(8'h81, 8'h7E);

    // R9: two bytes under one select.
    txByte = 8'h5A;
    waitClk(2);
    selN = 1'b0;
    waitClk(H);
    txByte = 8'hE1;
    d0 = doneCnt;
    shiftBits(8'h69, 8, got);
    checkByteEnd(8'h69, 8'h5A, got, d0);
    d0 = doneCnt;
    shiftBits(8'hF0, 8, got);
    checkByteEnd(8'hF0, 8'hE1, got, d0);
    chk(got == 8'hE1, "R9 second byte reloaded", got, 8'hE1);
    selN = 1'b1;
    waitClk(4);

    chk(widePulses == 0, "R6 done one cycle wide", widePulses, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule